// File: doc/BRIEF.md
# Asynchronous SRAM Controller with Byte Lanes

This block sits between a synchronous requester and an external asynchronous static memory of 256K words by 16 bits. It accepts one read or one write at a time through a request/ready handshake. Each access carries an 18-bit word address, 16-bit write data and a 2-bit byte mask. The controller then drives the memory's active-low chip enable, output enable, write enable and per-byte enables. Read data comes back on a dedicated bus with a one-cycle valid pulse.

Every strobe is registered. Each phase length is a cycle count that the block derives at elaboration from the clock period and the memory's nanosecond limits. These limits are the read cycle time, the output-enable access time, the write pulse width, the data setup time, the write cycle time and the output float delay. With the default 10 ns clock, a read holds its strobes for 5 cycles, a write holds write enable low for 4 cycles, and a read is followed by 2 turnaround cycles. The data pins are split into an output, an output-enable and an input, so that a pad-level tri-state buffer can join them.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted, chip enable, output enable, write enable and both byte enables are high, the data driver is off, ready is high and read-valid is low.
- R2: Ready is high only when no access is in progress. A request is taken on a clock edge where req_i and ready_o are both high. Ready stays low from that edge until the access, including any turnaround, has finished.
- R3: A read holds chip enable and output enable low together for RD cycles, where RD is the larger of ceil(45 ns / period) and ceil(22 ns / period). The data is sampled on the edge that raises them. rvalid_o is high for exactly the one following cycle, with the word on rdata_o.
- R4: A write holds write enable low for WE cycles, where WE is the largest of ceil(35 ns / period), ceil(25 ns / period) and ceil(45 ns / period) - 1. The write data is driven from the first low cycle. Write enable rises one cycle before chip enable and the byte enables rise. The data driver stays on until chip enable rises.
- R5: Byte mask bit 0 selects the lower byte (data bits 7:0) and drives mem_lane_no[0] low. Bit 1 selects the upper byte (bits 15:8) and drives mem_lane_no[1] low. A lane whose mask bit is 0 stays high for the whole access, so a write leaves that byte of the memory unchanged. Both lane enables are high whenever chip enable is high.
- R6: The memory address is the requested address. The address and the byte enables do not change while chip enable is low.
- R7: After a read, ready stays low for TURN = ceil(18 ns / period) cycles, counted from the edge that raises output enable. The data driver is not switched on until more than that float time has passed since the memory last drove the bus.
- R8: Output enable is never low while write enable is low or while the data driver is on.
- R9: A read of an address returns, on every enabled lane, the byte most recently written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| be_i | input | DATA_W/8 | Byte mask, bit 0 = lower byte |
| ready_o | output | 1 | Controller can accept a request |
| rdata_o | output | DATA_W | Read data |
| rvalid_o | output | 1 | Read data valid, one cycle |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_ce_no | output | 1 | Memory chip enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_lane_no | output | DATA_W/8 | Memory byte enables, active low, bit 0 = lower byte |
| mem_dq_o | output | DATA_W | Data toward memory |
| mem_dq_oe_o | output | 1 | Data driver enable |
| mem_dq_i | input | DATA_W | Data from memory |

## Verification
The properties assume a requester that keeps req_i and the access fields steady until the handshake edge. They also assume that the clock-period parameter matches the actual clock, since every strobe window is a cycle count derived from it. The bench drives each request on a falling edge only after it has seen ready high, releases it one cycle later, and runs the controller with its period parameter set to the bench clock. A cycle-based memory model beside the bench returns deliberately corrupted bytes until the read access time has elapsed. The same model records violations of the write pulse width, the data setup time, address stability, bus contention and float time.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_WEND,
    ST_TURN
  } st_e;

  function automatic int unsigned cdiv(int unsigned n, int unsigned d);
    return (n + d - 1) / d;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_load_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                rd_cap_i,
  input  logic [DATA_W/8-1:0] lane_en_i,
  input  logic [DATA_W-1:0]   dq_i,
  output logic [DATA_W-1:0]   dq_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                rvalid_o
);

  localparam int unsigned LANES = DATA_W / 8;

  logic [DATA_W-1:0] wdata_q;
  logic              rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (wr_load_i) wdata_q <= wdata_i;
      rvalid_q <= rd_cap_i;
    end
  end

  // per-lane capture; disabled lanes keep their old byte
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      byte_q <= '0;
      else if (rd_cap_i && lane_en_i[g]) byte_q <= dq_i[g*8 +: 8];
    end
    assign rdata_o[g*8 +: 8] = byte_q;
  end

  assign dq_o     = wdata_q;
  assign rvalid_o = rvalid_q;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CLK_NS   = 10,
  parameter int unsigned T_RC_NS  = 45,
  parameter int unsigned T_DOE_NS = 22,
  parameter int unsigned T_WC_NS  = 45,
  parameter int unsigned T_PWE_NS = 35,
  parameter int unsigned T_SD_NS  = 25,
  parameter int unsigned T_HZ_NS  = 18
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [DATA_W/8-1:0] be_i,
  output logic                ready_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                rvalid_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic                mem_ce_no,
  output logic                mem_oe_no,
  output logic                mem_we_no,
  output logic [DATA_W/8-1:0] mem_lane_no,
  output logic [DATA_W-1:0]   mem_dq_o,
  output logic                mem_dq_oe_o,
  input  logic [DATA_W-1:0]   mem_dq_i
);

  localparam int unsigned LANES    = DATA_W / 8;
  localparam int unsigned RD_CYC   = umax(cdiv(T_RC_NS, CLK_NS), cdiv(T_DOE_NS, CLK_NS));
  localparam int unsigned WE_CYC   = umax(umax(cdiv(T_PWE_NS, CLK_NS), cdiv(T_SD_NS, CLK_NS)),
                                          cdiv(T_WC_NS, CLK_NS) - 1);
  localparam int unsigned TURN_CYC = umax(cdiv(T_HZ_NS, CLK_NS), 1);
  localparam int unsigned CNT_MAX  = umax(umax(RD_CYC, WE_CYC), TURN_CYC);
  localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1);

  st_e               state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              ce_n_q, oe_n_q, we_n_q, dq_oe_q;
  logic [LANES-1:0]  lane_n_q;

  logic              tmr_load, tmr_done;
  logic [CNT_W-1:0]  tmr_val;
  logic              accept, wr_load, rd_cap;

  assign ready_o = (state_q == ST_IDLE);
  assign accept  = ready_o && req_i;
  assign wr_load = accept && we_i;
  assign rd_cap  = (state_q == ST_RD) && tmr_done;

  always_comb begin
    tmr_load = accept || rd_cap;
    if (accept) tmr_val = we_i ? CNT_W'(WE_CYC - 1) : CNT_W'(RD_CYC - 1);
    else        tmr_val = CNT_W'(TURN_CYC - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      ce_n_q   <= 1'b1;
      oe_n_q   <= 1'b1;
      we_n_q   <= 1'b1;
      dq_oe_q  <= 1'b0;
      lane_n_q <= '1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          addr_q   <= addr_i;
          lane_n_q <= ~be_i;
          ce_n_q   <= 1'b0;
          if (we_i) begin
            we_n_q  <= 1'b0;
            dq_oe_q <= 1'b1;
            state_q <= ST_WR;
          end else begin
            oe_n_q  <= 1'b0;
            state_q <= ST_RD;
          end
        end
        ST_RD: if (tmr_done) begin
          ce_n_q   <= 1'b1;
          oe_n_q   <= 1'b1;
          lane_n_q <= '1;
          state_q  <= ST_TURN;
        end
        ST_WR: if (tmr_done) begin
          we_n_q  <= 1'b1;   // write ends on WE edge, CE/lanes one cycle later
          state_q <= ST_WEND;
        end
        ST_WEND: begin
          ce_n_q   <= 1'b1;
          lane_n_q <= '1;
          dq_oe_q  <= 1'b0;
          state_q  <= ST_IDLE;
        end
        ST_TURN: if (tmr_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  sram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  sram_dq_path #(.DATA_W(DATA_W)) u_dq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_load_i (wr_load),
    .wdata_i   (wdata_i),
    .rd_cap_i  (rd_cap),
    .lane_en_i (~lane_n_q),
    .dq_i      (mem_dq_i),
    .dq_o      (mem_dq_o),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o)
  );

  assign mem_addr_o  = addr_q;
  assign mem_ce_no   = ce_n_q;
  assign mem_oe_no   = oe_n_q;
  assign mem_we_no   = we_n_q;
  assign mem_lane_no = lane_n_q;
  assign mem_dq_oe_o = dq_oe_q;

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned LANES  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              rvalid_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ce_no,
  input logic              mem_oe_no,
  input logic              mem_we_no,
  input logic [LANES-1:0]  mem_lane_no,
  input logic              mem_dq_oe_o
);

  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni) !mem_ce_no |-> !ready_o); // R2
  AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) rvalid_o |=> !rvalid_o); // R3
  AST_RVALID_AT_READ_END: assert property (@(posedge clk_i) disable iff (!rst_ni) rvalid_o |-> $rose(mem_oe_no)); // R3
  AST_WE_RISES_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(mem_we_no) |-> !mem_ce_no); // R4
  AST_DATA_HELD_TO_CE: assert property (@(posedge clk_i) disable iff (!rst_ni) ($rose(mem_ce_no) && $past(mem_oe_no)) |-> $past(mem_dq_oe_o) && $past(mem_we_no)); // R4
  AST_DRIVE_IN_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni) mem_dq_oe_o |-> !mem_ce_no); // R4
  AST_LANES_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) mem_ce_no |-> &mem_lane_no); // R5
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni) (!mem_ce_no && $past(!mem_ce_no)) |-> $stable(mem_addr_o) && $stable(mem_lane_no)); // R6
  AST_TURN_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(mem_oe_no) |-> !ready_o); // R7
  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni) !(mem_dq_oe_o && !mem_oe_no)); // R8
  AST_OE_WE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni) !(!mem_oe_no && !mem_we_no)); // R8

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(DATA_W/8)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ready_o     (ready_o),
  .rvalid_o    (rvalid_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ce_no   (mem_ce_no),
  .mem_oe_no   (mem_oe_no),
  .mem_we_no   (mem_we_no),
  .mem_lane_no (mem_lane_no),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/sram_ctrl_bench.sv
`timescale 1ns/1ps
module sram_ctrl_bench;

  localparam int CLK_NS = 5;
  function automatic int cdiv(int n, int d); return (n + d - 1) / d; endfunction
  function automatic int imax(int a, int b); return (a > b) ? a : b; endfunction
  localparam int RD_EXP   = imax(cdiv(45, CLK_NS), cdiv(22, CLK_NS));
  localparam int WE_EXP   = imax(imax(cdiv(35, CLK_NS), cdiv(25, CLK_NS)), cdiv(45, CLK_NS) - 1);
  localparam int TURN_EXP = cdiv(18, CLK_NS);
  localparam int PWE_MIN  = cdiv(35, CLK_NS);
  localparam int SD_MIN   = cdiv(25, CLK_NS);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [17:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  bmask = '0;
  logic        ready_o, rvalid_o;
  logic [15:0] rdata_o;
  logic [17:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, dq_oe;
  logic [1:0]  mem_lane_n;
  logic [15:0] dq_o, dq_in = 16'hEEEE;

  always #2.5 clk = ~clk;

  sram_ctrl #(.CLK_NS(CLK_NS)) u_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(bmask), .ready_o(ready_o), .rdata_o(rdata_o),
    .rvalid_o(rvalid_o), .mem_addr_o(mem_addr), .mem_ce_no(mem_ce_n),
    .mem_oe_no(mem_oe_n), .mem_we_no(mem_we_n), .mem_lane_no(mem_lane_n),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_in)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // ---------------- cycle-based memory model ----------------
  logic [15:0] mem_m [int];
  logic [15:0] ref_m [int];
  int v_bus = 0, v_turn = 0, v_stab = 0, v_wr = 0;
  int since_drv = 1000, wcnt = 0, dstab = 0, rcnt = 0;
  logic        p_ce = 1'b1, p_wr = 1'b0;
  logic [17:0] p_addr = '0;
  logic [1:0]  p_lanes = 2'b11;
  logic [15:0] p_dq = '0;

  function automatic logic [15:0] m_rd(int k);
    return mem_m.exists(k) ? mem_m[k] : 16'h0000;
  endfunction
  function automatic logic [15:0] r_rd(int k);
    return ref_m.exists(k) ? ref_m[k] : 16'h0000;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      logic drv, wr_act;
      logic [15:0] w, nd;
      drv    = !mem_ce_n && !mem_oe_n && mem_we_n;
      wr_act = !mem_ce_n && !mem_we_n && (mem_lane_n != 2'b11);
      if (dq_oe && drv) v_bus++;
      if (drv) since_drv = 0; else if (since_drv < 1000) since_drv++;
      if (dq_oe && since_drv <= TURN_EXP) v_turn++;
      if (!mem_ce_n && !p_ce && (mem_addr != p_addr || mem_lane_n != p_lanes)) v_stab++;
      if (wr_act) begin
        wcnt++;
        if (dq_oe && p_wr && dq_o == p_dq) dstab++;
        else dstab = dq_oe ? 1 : 0;
      end else if (p_wr) begin
        if (wcnt < PWE_MIN || dstab < SD_MIN) v_wr++;
        w = m_rd(int'(p_addr));
        if (!p_lanes[0]) w[7:0]  = p_dq[7:0];
        if (!p_lanes[1]) w[15:8] = p_dq[15:8];
        mem_m[int'(p_addr)] = w;
        wcnt = 0; dstab = 0;
      end
      if (!mem_ce_n && !mem_oe_n) rcnt++; else rcnt = 0;
      w  = m_rd(int'(mem_addr));
      nd = 16'hEEEE;
      if (drv) begin
        if (!mem_lane_n[0]) nd[7:0]  = (rcnt >= RD_EXP) ? w[7:0]  : ~w[7:0];
        if (!mem_lane_n[1]) nd[15:8] = (rcnt >= RD_EXP) ? w[15:8] : ~w[15:8];
      end
      dq_in   = nd;
      p_ce    = mem_ce_n;
      p_wr    = wr_act;
      p_addr  = mem_addr;
      p_lanes = mem_lane_n;
      p_dq    = dq_o;
    end
  end

  // ---------------- scenario tasks ----------------
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1", "strobes in reset",
        {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    chk(mem_lane_n == 2'b11, "R1", "lanes in reset", mem_lane_n, 2'b11);
    chk(!dq_oe, "R1", "driver in reset", dq_oe, 0);
    chk(ready_o && !rvalid_o, "R1", "ready/rvalid in reset", {ready_o, rvalid_o}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    int n = 0;
    bit b_rdy = 0, b_addr = 0, b_lane = 0, b_dq = 0, b_oe = 0;
    logic [15:0] w;
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; bmask = be;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    while (!mem_we_n && n < 100) begin
      if (ready_o) b_rdy = 1;
      if (mem_addr != a) b_addr = 1;
      if (mem_lane_n != ~be) b_lane = 1;
      if (!dq_oe || dq_o != d) b_dq = 1;
      if (!mem_oe_n) b_oe = 1;
      n++;
      @(negedge clk);
    end
    chk(n == WE_EXP, "R4", "write-enable low cycles", n, WE_EXP);
    chk(!b_dq, "R4", "write data driven during pulse", b_dq, 0);
    chk(!b_rdy, "R2", "ready low during write", b_rdy, 0);
    chk(!b_addr, "R6", "address during write", b_addr, 0);
    chk(!b_lane, "R5", "lane enables during write", b_lane, 0);
    chk(!b_oe, "R8", "output enable high during write", b_oe, 0);
    chk(!mem_ce_n && mem_lane_n == ~be && dq_oe, "R4", "WE rises before CE/lanes",
        {mem_ce_n, mem_lane_n, dq_oe}, {1'b0, ~be, 1'b1});
    @(negedge clk);
    chk(mem_ce_n && mem_lane_n == 2'b11 && !dq_oe, "R4", "release after write",
        {mem_ce_n, mem_lane_n, dq_oe}, 4'b1110);
    chk(ready_o, "R2", "ready after write", ready_o, 1);
    w = r_rd(int'(a));
    if (be[0]) w[7:0]  = d[7:0];
    if (be[1]) w[15:8] = d[15:8];
    ref_m[int'(a)] = w;
  endtask

  task automatic do_read(input logic [17:0] a, input logic [1:0] be);
    int n = 0, t = 0, nv = 0;
    bit b_rdy = 0, b_addr = 0, b_lane = 0, b_str = 0;
    logic [15:0] exp, msk;
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; bmask = be; wdata = 16'h0BAD;
    @(negedge clk);
    req = 1'b0;
    while (!mem_ce_n && n < 100) begin
      if (ready_o) b_rdy = 1;
      if (mem_addr != a) b_addr = 1;
      if (mem_lane_n != ~be) b_lane = 1;
      if (mem_oe_n || !mem_we_n || dq_oe) b_str = 1;
      n++;
      @(negedge clk);
    end
    chk(n == RD_EXP, "R3", "read strobe cycles", n, RD_EXP);
    chk(!b_str, "R8", "OE low, WE high, driver off in read", b_str, 0);
    chk(!b_rdy, "R2", "ready low during read", b_rdy, 0);
    chk(!b_addr, "R6", "address during read", b_addr, 0);
    chk(!b_lane, "R5", "lane enables during read", b_lane, 0);
    chk(rvalid_o, "R3", "rvalid after strobes rise", rvalid_o, 1);
    exp = r_rd(int'(a));
    msk = {{8{be[1]}}, {8{be[0]}}};
    chk((rdata_o & msk) == (exp & msk), "R9", "read data", rdata_o & msk, exp & msk);
    while (!ready_o && t < 100) begin
      if (rvalid_o) nv++;
      t++;
      @(negedge clk);
    end
    chk(t == TURN_EXP, "R7", "turnaround cycles", t, TURN_EXP);
    chk(nv == 1, "R3", "rvalid pulse width", nv, 1);
  endtask

  task automatic t_lanes();
    do_write(18'h00010, 16'hA5C3, 2'b11);
    do_read (18'h00010, 2'b11);
    do_write(18'h00010, 16'h1234, 2'b01);   // upper byte kept
    do_read (18'h00010, 2'b11);
    chk(rdata_o == 16'hA534, "R5", "lower-only write result", rdata_o, 16'hA534);
    do_write(18'h00010, 16'h9876, 2'b10);   // lower byte kept
    do_read (18'h00010, 2'b10);
    do_read (18'h00010, 2'b11);
    chk(rdata_o == 16'h9834, "R5", "upper-only write result", rdata_o, 16'h9834);
  endtask

  task automatic t_edges();
    do_write(18'h3FFFF, 16'h5AA5, 2'b11);
    do_write(18'h00000, 16'h0F0F, 2'b11);
    do_read (18'h3FFFF, 2'b11);
    do_read (18'h00000, 2'b01);
    do_write(18'h00000, 16'hC33C, 2'b11);   // write right after read
    do_read (18'h00000, 2'b11);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 8; i++)
      do_write(18'((i * 32'h8421) & 32'h3FFFF), 16'(16'h1111 * (i + 1) ^ 16'h0F0F), 2'b11);
    for (int i = 7; i >= 0; i--)
      do_read(18'((i * 32'h8421) & 32'h3FFFF), 2'b11);
  endtask

  bit done = 0;

  initial begin
    t_reset();
    t_lanes();
    t_edges();
    t_sweep();
    repeat (4) @(negedge clk);
    chk(v_bus == 0, "R8", "model bus contention events", v_bus, 0);
    chk(v_turn == 0, "R7", "model float-time violations", v_turn, 0);
    chk(v_stab == 0, "R6", "model address/lane changes", v_stab, 0);
    chk(v_wr == 0, "R4", "model write pulse/setup violations", v_wr, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule